// File: doc/BRIEF.md
# Receive FIFO Host Read Port

This block connects a 32-bit host register bus to two receive-side queues: a status queue holding per-frame descriptors and a data queue holding payload words. It decodes host read addresses (given as DWORD word addresses) and turns each read strobe into at most one queue access. The status queue answers at two addresses. One read is destructive and removes the head entry. The other read only inspects the head entry. The data queue answers at a window of aliased word addresses, and a read at any alias removes the head word.

The alias window is 8 words wide when the bus-mode input `bus_narrow` is low and 16 words wide when it is high. Both queues have a simple push interface with a full flag so that the receive side, or a testbench, can load them. Host writes to any of these addresses are ignored.

Top module: `rx_host_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, both queues are empty, `sts_full`, `dat_full` and `dat_underrun` are 0, and `host_rdata` is 0.
- R2: A read strobe at word address 16 (status pop) returns the status head entry and removes it, and entries leave in push order.
- R3: A read strobe at word address 17 (status peek) returns the status head entry and leaves the queue unchanged, so repeated peeks return the same entry.
- R4: With `bus_narrow` = 0, reads at word addresses 0 to 7 each return and remove the data head word. A read at word addresses 8 to 15 returns 0 and removes nothing.
- R5: With `bus_narrow` = 1, reads at word addresses 0 to 15 each return and remove the data head word.
- R6: A read strobe held high for several cycles performs exactly one access. The access happens in its first cycle.
- R7: Asserting `host_wr` at any address changes neither queue, `host_rdata` nor `dat_underrun`.
- R8: A pop or peek read while the status queue is empty returns 0 and changes no pointer.
- R9: A data read while the data queue is empty returns 0 and sets `dat_underrun`. The flag stays at 1 until reset, even after later successful reads.
- R10: A full flag rises when its queue holds its depth of entries (4 status, 16 data by default). A push while full is dropped.
- R11: `host_rdata` takes its new value at the clock edge that ends the first cycle of a read strobe and holds it until the next strobe. A read at an unmapped word address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_narrow | input | 1 | 1 selects the 16-word data alias window, 0 selects the 8-word window |
| host_rd | input | 1 | Host read strobe, level; one access per rising strobe |
| host_wr | input | 1 | Host write strobe; ignored by these read-only ports |
| host_addr | input | ADDR_W | Host DWORD word address |
| host_rdata | output | 32 | Registered read data |
| sts_push | input | 1 | Push one entry into the status queue |
| sts_din | input | 32 | Status entry to push |
| sts_full | output | 1 | Status queue full |
| dat_push | input | 1 | Push one word into the data queue |
| dat_din | input | 32 | Data word to push |
| dat_full | output | 1 | Data queue full |
| dat_underrun | output | 1 | Sticky flag: a data read found the queue empty |

## Verification
The bench goes after the alias window boundary. If the window width ignores `bus_narrow`, a read at word 8 or 12 pops in the wrong mode, and every later data value shifts by one. A held read strobe checks that the block pops once per strobe and not once per cycle. Peeks alternate with pops, so a peek that removes the entry shows up as a skipped descriptor. Empty reads, writes to every port, the full boundary and a reset with data in the queues are also exercised. A cycle-by-cycle reference model catches any stray change of data, flags or ordering.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_STS_POP,
        PORT_STS_PEEK,
        PORT_DATA
    } port_sel_e;

    // head of a queue as seen by the read mux
    typedef struct packed {
        logic  avail;
        word_t word;
    } head_t;

    // word returned for a head: zero when nothing is there
    function automatic word_t head_value(head_t h);
        return h.avail ? h.word : '0;
    endfunction

endpackage

// File: rtl/rxp_fifo.sv
module rxp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT) else $error("queue count above depth"); // R10

    AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (full && $stable(wr_ptr))) else $error("push accepted while full"); // R10

    AST_EMPTY_POP_SAFE: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (empty && $stable(rd_ptr))) else $error("pop moved pointer while empty"); // R8

endmodule

// File: rtl/rxp_decode.sv
module rxp_decode
    import rxp_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int ALIAS_LOG2    = 3,
    parameter int DATA_BASE     = 0,
    parameter int STS_POP_ADDR  = 16,
    parameter int STS_PEEK_ADDR = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    output port_sel_e         sel
);

    localparam logic [ADDR_W:0]   WIN_WIDE   = (ADDR_W+1)'(1) << ALIAS_LOG2;
    localparam logic [ADDR_W:0]   WIN_NARROW = (ADDR_W+1)'(1) << (ALIAS_LOG2 + 1);
    localparam logic [ADDR_W-1:0] BASE_A     = ADDR_W'(DATA_BASE);
    localparam logic [ADDR_W-1:0] POP_A      = ADDR_W'(STS_POP_ADDR);
    localparam logic [ADDR_W-1:0] PEEK_A     = ADDR_W'(STS_PEEK_ADDR);

    logic [ADDR_W-1:0] offs;
    logic              data_hit;

    // addresses below the base wrap high and miss the window
    assign offs     = addr - BASE_A;
    assign data_hit = narrow ? ({1'b0, offs} < WIN_NARROW)
                             : ({1'b0, offs} < WIN_WIDE);

    always_comb begin
        if (addr == POP_A) begin
            sel = PORT_STS_POP;
        end else if (addr == PEEK_A) begin
            sel = PORT_STS_PEEK;
        end else if (data_hit) begin
            sel = PORT_DATA;
        end else begin
            sel = PORT_NONE;
        end
    end

endmodule

// File: rtl/rx_host_port.sv
module rx_host_port
    import rxp_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int STS_DEPTH     = 4,
    parameter int DAT_DEPTH     = 16,
    parameter int ALIAS_LOG2    = 3,
    parameter int DATA_BASE     = 0,
    parameter int STS_POP_ADDR  = 16,
    parameter int STS_PEEK_ADDR = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_narrow,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [31:0]       host_rdata,
    input  logic              sts_push,
    input  logic [31:0]       sts_din,
    output logic              sts_full,
    input  logic              dat_push,
    input  logic [31:0]       dat_din,
    output logic              dat_full,
    output logic              dat_underrun
);

    localparam int STS_CW = $clog2(STS_DEPTH + 1);
    localparam int DAT_CW = $clog2(DAT_DEPTH + 1);

    port_sel_e         sel;
    logic              rd_q;
    logic              rd_start;
    logic              sts_pop;
    logic              dat_pop;
    logic              sts_empty;
    logic              dat_empty;
    word_t             sts_head_w;
    word_t             dat_head_w;
    head_t             sts_head;
    head_t             dat_head;
    word_t             rdata_next;
    logic [STS_CW-1:0] sts_count;
    logic [DAT_CW-1:0] dat_count;

    rxp_decode #(
        .ADDR_W       (ADDR_W),
        .ALIAS_LOG2   (ALIAS_LOG2),
        .DATA_BASE    (DATA_BASE),
        .STS_POP_ADDR (STS_POP_ADDR),
        .STS_PEEK_ADDR(STS_PEEK_ADDR)
    ) u_decode (
        .addr  (host_addr),
        .narrow(bus_narrow),
        .sel   (sel)
    );

    rxp_fifo #(.DEPTH(STS_DEPTH), .W(WORD_W)) u_sts_q (
        .clk  (clk),
        .rst  (rst),
        .push (sts_push),
        .din  (sts_din),
        .pop  (sts_pop),
        .head (sts_head_w),
        .empty(sts_empty),
        .full (sts_full),
        .count(sts_count)
    );

    rxp_fifo #(.DEPTH(DAT_DEPTH), .W(WORD_W)) u_dat_q (
        .clk  (clk),
        .rst  (rst),
        .push (dat_push),
        .din  (dat_din),
        .pop  (dat_pop),
        .head (dat_head_w),
        .empty(dat_empty),
        .full (dat_full),
        .count(dat_count)
    );

    // one access per strobe: act only in its first cycle
    assign rd_start = host_rd && !rd_q;
    assign sts_head = '{avail: !sts_empty, word: sts_head_w};
    assign dat_head = '{avail: !dat_empty, word: dat_head_w};
    assign sts_pop  = rd_start && (sel == PORT_STS_POP) && !sts_empty;
    assign dat_pop  = rd_start && (sel == PORT_DATA) && !dat_empty;

    always_comb begin
        case (sel)
            PORT_STS_POP,
            PORT_STS_PEEK: rdata_next = head_value(sts_head);
            PORT_DATA:     rdata_next = head_value(dat_head);
            default:       rdata_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q         <= 1'b0;
            host_rdata   <= '0;
            dat_underrun <= 1'b0;
        end else begin
            rd_q <= host_rd;
            if (rd_start) begin
                host_rdata <= rdata_next;
                if (sel == PORT_DATA && dat_empty) begin
                    dat_underrun <= 1'b1;
                end
            end
        end
    end

    AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (host_rd && $past(host_rd) && !sts_push && !dat_push)
        |=> ($stable(sts_count) && $stable(dat_count))) else $error("held strobe accessed twice"); // R6

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !$past(host_rd) && host_addr == ADDR_W'(STS_PEEK_ADDR) && !sts_push)
        |=> $stable(sts_count)) else $error("peek removed an entry"); // R3

    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_rd && !sts_push && !dat_push)
        |=> ($stable(sts_count) && $stable(dat_count) && $stable(host_rdata))) else $error("write changed state"); // R7

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        dat_underrun |=> dat_underrun) else $error("underrun flag cleared"); // R9

    AST_EMPTY_STS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_start && sts_empty && (sel == PORT_STS_POP || sel == PORT_STS_PEEK))
        |=> (host_rdata == '0)) else $error("empty status read not zero"); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!host_rd && !rd_start) |=> $stable(host_rdata)) else $error("read data moved without strobe"); // R11

endmodule

// File: tb/rx_host_port_test.sv
module rx_host_port_test;

    localparam int STS_D = 4;
    localparam int DAT_D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_narrow = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_rdata;
    logic        sts_push = 1'b0;
    logic [31:0] sts_din = '0;
    logic        sts_full;
    logic        dat_push = 1'b0;
    logic [31:0] dat_din = '0;
    logic        dat_full;
    logic        dat_underrun;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    rx_host_port uut (
        .clk         (clk),
        .rst         (rst),
        .bus_narrow  (bus_narrow),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_rdata  (host_rdata),
        .sts_push    (sts_push),
        .sts_din     (sts_din),
        .sts_full    (sts_full),
        .dat_push    (dat_push),
        .dat_din     (dat_din),
        .dat_full    (dat_full),
        .dat_underrun(dat_underrun)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq_s[$];
    logic [31:0] mq_d[$];
    logic [31:0] m_rdata = '0;
    bit          m_under = 0;
    bit          m_rdq = 0;
    bit          m_sfull;
    bit          m_dfull;
    int          m_win;

    always @(posedge clk) begin
        if (rst) begin
            mq_s.delete();
            mq_d.delete();
            m_rdata = '0;
            m_under = 0;
            m_rdq   = 0;
        end else begin
            m_sfull = (mq_s.size() >= STS_D);
            m_dfull = (mq_d.size() >= DAT_D);
            m_win   = bus_narrow ? 16 : 8;
            if (host_rd && !m_rdq) begin
                if (host_addr == 6'd16 || host_addr == 6'd17) begin
                    if (mq_s.size() > 0) begin
                        m_rdata = mq_s[0];
                        if (host_addr == 6'd16) void'(mq_s.pop_front());
                    end else begin
                        m_rdata = '0;
                    end
                end else if (int'(host_addr) < m_win) begin
                    if (mq_d.size() > 0) begin
                        m_rdata = mq_d.pop_front();
                    end else begin
                        m_rdata = '0;
                        m_under = 1;
                    end
                end else begin
                    m_rdata = '0;
                end
            end
            if (sts_push && !m_sfull) mq_s.push_back(sts_din);
            if (dat_push && !m_dfull) mq_d.push_back(dat_din);
            m_rdq = host_rd;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (host_rdata !== m_rdata || sts_full !== (mq_s.size() == STS_D) ||
                dat_full !== (mq_d.size() == DAT_D) || dat_underrun !== m_under) begin
                errors++;
                $display("FAIL model %s: actual rdata=%h sf=%b df=%b un=%b expected rdata=%h sf=%b df=%b un=%b",
                         cur_req, host_rdata, sts_full, dat_full, dat_underrun,
                         m_rdata, mq_s.size() == STS_D, mq_d.size() == DAT_D, m_under);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, input logic nar, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_narrow = nar;
        host_addr  = a;
        host_rd    = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check(host_rdata, exp, tag);
    endtask

    task automatic push_s(input logic [31:0] v);
        @(negedge clk);
        sts_push = 1'b1;
        sts_din  = v;
        @(negedge clk);
        sts_push = 1'b0;
    endtask

    task automatic push_d(input logic [31:0] v);
        @(negedge clk);
        dat_push = 1'b1;
        dat_din  = v;
        @(negedge clk);
        dat_push = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check({31'd0, sts_full}, 32'd0, "R1 sts_full in reset");
        check({31'd0, dat_full}, 32'd0, "R1 dat_full in reset");
        check(host_rdata, 32'd0, "R1 rdata in reset");
        rst = 1'b0;
        @(negedge clk);
        check({31'd0, dat_underrun}, 32'd0, "R1 underrun after reset");

        cur_req = "R8";
        rd(6'd16, 1'b0, 32'd0, "R8 pop empty status");
        rd(6'd17, 1'b0, 32'd0, "R8 peek empty status");

        cur_req = "R10";
        push_s(32'hA0); push_s(32'hA1); push_s(32'hA2); push_s(32'hA3);
        check({31'd0, sts_full}, 32'd1, "R10 status full at depth");
        push_s(32'hEE);

        cur_req = "R3";
        rd(6'd17, 1'b0, 32'hA0, "R3 peek head");
        rd(6'd17, 1'b0, 32'hA0, "R3 peek again same head");
        cur_req = "R2";
        rd(6'd16, 1'b0, 32'hA0, "R2 pop first");
        rd(6'd16, 1'b0, 32'hA1, "R2 pop second in order");
        check({31'd0, sts_full}, 32'd0, "R10 status not full after pops");

        cur_req = "R4";
        for (int i = 1; i <= 8; i++) push_d(32'(i));
        rd(6'd3, 1'b0, 32'd1, "R4 alias 3 wide");
        rd(6'd7, 1'b0, 32'd2, "R4 alias 7 wide");
        rd(6'd8, 1'b0, 32'd0, "R4 word 8 outside wide window");
        rd(6'd0, 1'b0, 32'd3, "R4 alias 0 after miss, no pop");
        cur_req = "R5";
        rd(6'd12, 1'b1, 32'd4, "R5 alias 12 narrow");
        rd(6'd15, 1'b1, 32'd5, "R5 alias 15 narrow");

        cur_req = "R6";
        @(negedge clk);
        bus_narrow = 1'b0;
        host_addr  = 6'd0;
        host_rd    = 1'b1;
        repeat (4) @(negedge clk);
        host_rd = 1'b0;
        check(host_rdata, 32'd6, "R6 held strobe value");
        rd(6'd1, 1'b0, 32'd7, "R6 only one pop for held strobe");

        cur_req = "R7";
        @(negedge clk);
        host_wr = 1'b1;
        host_addr = 6'd16;
        repeat (3) @(negedge clk);
        host_addr = 6'd0;
        repeat (3) @(negedge clk);
        host_addr = 6'd17;
        repeat (2) @(negedge clk);
        host_wr = 1'b0;
        check(host_rdata, 32'd7, "R7 rdata unchanged by writes");
        rd(6'd16, 1'b0, 32'hA2, "R7 status intact after writes");
        rd(6'd5, 1'b0, 32'd8, "R7 data intact after writes");

        cur_req = "R9";
        rd(6'd2, 1'b0, 32'd0, "R9 empty data read zero");
        check({31'd0, dat_underrun}, 32'd1, "R9 underrun set");
        push_d(32'd9);
        rd(6'd4, 1'b0, 32'd9, "R9 read after refill");
        check({31'd0, dat_underrun}, 32'd1, "R9 underrun sticky");

        cur_req = "R11";
        repeat (3) @(negedge clk);
        check(host_rdata, 32'd9, "R11 rdata held while idle");
        rd(6'd40, 1'b1, 32'd0, "R11 unmapped address zero");
        rd(6'd16, 1'b0, 32'hA3, "R2 last status entry");
        rd(6'd16, 1'b0, 32'd0, "R8 status empty again");

        cur_req = "R10";
        for (int i = 0; i < DAT_D; i++) push_d(32'h100 + 32'(i));
        check({31'd0, dat_full}, 32'd1, "R10 data full at depth");
        push_d(32'hDEAD);
        for (int i = 0; i < DAT_D; i++) rd(6'(i), 1'b1, 32'h100 + 32'(i), "R10 data drain order");
        rd(6'd0, 1'b1, 32'd0, "R10 dropped push not stored");

        cur_req = "R1";
        push_s(32'hB0);
        push_d(32'hC0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(host_rdata, 32'd0, "R1 rdata cleared by reset");
        check({31'd0, dat_underrun}, 32'd0, "R1 underrun cleared by reset");
        rst = 1'b0;
        rd(6'd16, 1'b0, 32'd0, "R1 status empty after reset");
        rd(6'd0, 1'b0, 32'd0, "R1 data empty after reset");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule